// File: doc/BRIEF.md
# DMA Channel Request Source Selector

This block sits in front of a 32-channel DMA engine and decides, channel by channel, which peripheral request line drives that channel. Each channel has three candidate request sources, called slots 0, 1 and 2. Two register views control the choice. The main view gives every channel a 4-bit select field that can name slot 0, 1 or 2. A narrower compatibility view gives every channel one bit that can name slot 0 or slot 1 only.

The two views overlap. For each channel, the view written most recently is the one in force. A per-channel flag records this. A select-field write sets the flag for the channels it covers, and a write to the compatibility register clears the flag on every channel. The block drives a 2-bit effective select per channel and routes the chosen request line to that channel's request output. A slot can be disabled at build time through a parameter; by default channels 30 and 31 have no hardware slot, so they serve software-started transfers only.

Software uses a plain register port. A write takes effect at the clock edge. Reads and request routing are combinational.

Top module: `chan_src_mapper`

## Requirements
- R1: After reset, all select fields and compatibility bits read as zero and every channel's `sel_o` is 0 (slot 0).
- R2: The select fields sit at word addresses 0 to 3. Channel c is at word c/8, bits [4*(c%8)+3 : 4*(c%8)]. Writing a word stores all eight fields of that word. A field value of 0, 1 or 2 makes `sel_o[2c+1:2c]` that value from the cycle after the write.
- R3: A select-field value of 3 to 15 gives `sel_o` = 3 (none) for that channel, and `chan_req_o` for that channel stays 0.
- R4: The compatibility register sits at word address 4, with bit c for channel c. After a write to it, each channel's `sel_o` is 0 where its bit is 0 and 1 where its bit is 1, never 2.
- R5: For each channel, the later of the two register writes decides `sel_o`. A select-field write overrides an earlier compatibility write, and a compatibility write overrides an earlier select-field write.
- R6: Reads return the stored select fields at addresses 0 to 3 and the stored compatibility bits at address 4, whichever view is in force.
- R7: `chan_req_o[c]` equals `req_i[3c+s]` for the effective slot s of channel c, in the same cycle that `req_i` changes.
- R8: A slot cleared in `SLOT_EN` never reaches the channel. With the default setting, `chan_req_o[30]` and `chan_req_o[31]` are always 0.
- R9: Writes to addresses 5 to 7 change no stored state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data (combinational) |
| req_i | input | 96 | Peripheral request lines; bit 3c+s is slot s of channel c |
| sel_o | output | 64 | Effective slot per channel; bits 2c+1:2c, where 3 means none |
| chan_req_o | output | 32 | Routed request per channel |

## Verification
A register write is sampled at one rising edge. Its effect on `sel_o`, on routing and on read data appears right after that edge, with no extra pipeline stage. The bench therefore drives a write at a falling edge, clears the strobe at the next falling edge, and compares everything at that point. Changes to `req_i` and `rd_addr_i` are combinational, so the bench checks them 1 ns after driving them, within the same cycle. The bound assertions use the same one-cycle offset (`|=>` after a write) for select and readback.

// File: rtl/chm_pkg.sv
package chm_pkg;
  localparam int N_SLOT = 3;
  localparam int SEL_W  = 2;
  localparam int FLD_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_S0   = 2'd0,
    SEL_S1   = 2'd1,
    SEL_S2   = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/chm_regs.sv
module chm_regs
  import chm_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [N_CH*FLD_W-1:0] fld_o,
  output logic [N_CH-1:0]       leg_o,
  output logic [N_CH-1:0]       fld_wins_o
);
  localparam int CH_PER_W  = DATA_W / FLD_W;
  localparam int FLD_WORDS = N_CH / CH_PER_W;
  localparam int LEG_ADDR  = FLD_WORDS;

  logic [N_CH*FLD_W-1:0] fld_q;
  logic [N_CH-1:0]       leg_q;
  logic [N_CH-1:0]       fld_wins_q;
  logic                  wr_leg;

  assign wr_leg = wr_en_i && (wr_addr_i == ADDR_W'(LEG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q      <= '0;
      leg_q      <= '0;
      fld_wins_q <= '0;
    end else if (wr_en_i) begin
      if (wr_leg) begin
        leg_q      <= wr_data_i[N_CH-1:0];
        fld_wins_q <= '0;  // legacy write takes every channel back
      end
      for (int c = 0; c < N_CH; c++) begin
        if (wr_addr_i == ADDR_W'(c / CH_PER_W)) begin
          fld_q[c*FLD_W +: FLD_W] <= wr_data_i[(c % CH_PER_W)*FLD_W +: FLD_W];
          fld_wins_q[c]           <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(LEG_ADDR)) rd_data_o[N_CH-1:0] = leg_q;
    for (int c = 0; c < N_CH; c++) begin
      if (rd_addr_i == ADDR_W'(c / CH_PER_W))
        rd_data_o[(c % CH_PER_W)*FLD_W +: FLD_W] = fld_q[c*FLD_W +: FLD_W];
    end
  end

  assign fld_o      = fld_q;
  assign leg_o      = leg_q;
  assign fld_wins_o = fld_wins_q;
endmodule

// File: rtl/chm_sel.sv
module chm_sel
  import chm_pkg::*;
#(
  parameter int N_CH = 32
) (
  input  logic [N_CH*FLD_W-1:0] fld_i,
  input  logic [N_CH-1:0]       leg_i,
  input  logic [N_CH-1:0]       fld_wins_i,
  output logic [N_CH*SEL_W-1:0] sel_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [FLD_W-1:0] fld;
    sel_e             sel;
    assign fld = fld_i[c*FLD_W +: FLD_W];
    always_comb begin
      if (!fld_wins_i[c])            sel = leg_i[c] ? SEL_S1 : SEL_S0;
      else if (fld > FLD_W'(SEL_S2)) sel = SEL_NONE;
      else                           sel = sel_e'(fld[SEL_W-1:0]);
    end
    assign sel_o[c*SEL_W +: SEL_W] = sel;
  end
endmodule

// File: rtl/chm_route.sv
module chm_route
  import chm_pkg::*;
#(
  parameter int                     N_CH    = 32,
  parameter logic [N_CH*N_SLOT-1:0] SLOT_EN = '1
) (
  input  logic [N_CH*N_SLOT-1:0] req_i,
  input  logic [N_CH*SEL_W-1:0]  sel_i,
  output logic [N_CH-1:0]        chan_req_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_SLOT-1:0] live;
    assign live = req_i[c*N_SLOT +: N_SLOT] & SLOT_EN[c*N_SLOT +: N_SLOT];
    always_comb begin
      unique case (sel_e'(sel_i[c*SEL_W +: SEL_W]))
        SEL_S0:  chan_req_o[c] = live[0];
        SEL_S1:  chan_req_o[c] = live[1];
        SEL_S2:  chan_req_o[c] = live[2];
        default: chan_req_o[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/chan_src_mapper.sv
module chan_src_mapper
  import chm_pkg::*;
#(
  parameter int                     N_CH    = 32,
  parameter int                     DATA_W  = 32,
  parameter int                     ADDR_W  = 3,
  parameter logic [N_CH*N_SLOT-1:0] SLOT_EN =
    {{(2*N_SLOT){1'b0}}, {((N_CH-2)*N_SLOT){1'b1}}}
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  input  logic [N_CH*N_SLOT-1:0] req_i,
  output logic [N_CH*SEL_W-1:0]  sel_o,
  output logic [N_CH-1:0]        chan_req_o
);
  logic [N_CH*FLD_W-1:0] fld;
  logic [N_CH-1:0]       leg;
  logic [N_CH-1:0]       fld_wins;

  chm_regs #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .fld_o      (fld),
    .leg_o      (leg),
    .fld_wins_o (fld_wins)
  );

  chm_sel #(.N_CH(N_CH)) u_sel (
    .fld_i      (fld),
    .leg_i      (leg),
    .fld_wins_i (fld_wins),
    .sel_o      (sel_o)
  );

  chm_route #(.N_CH(N_CH), .SLOT_EN(SLOT_EN)) u_route (
    .req_i      (req_i),
    .sel_i      (sel_o),
    .chan_req_o (chan_req_o)
  );
endmodule

// File: rtl/chan_src_mapper_chk.sv
module chan_src_mapper_chk
  import chm_pkg::*;
#(
  parameter int                     N_CH    = 32,
  parameter int                     DATA_W  = 32,
  parameter int                     ADDR_W  = 3,
  parameter logic [N_CH*N_SLOT-1:0] SLOT_EN = '1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [DATA_W-1:0]     wr_data_i,
  input logic [ADDR_W-1:0]     rd_addr_i,
  input logic [DATA_W-1:0]     rd_data_o,
  input logic [N_CH*SEL_W-1:0] sel_o,
  input logic [N_CH-1:0]       chan_req_o
);
  localparam int CH_PER_W = DATA_W / FLD_W;
  localparam int LEG_ADDR = N_CH / CH_PER_W;

  logic [N_CH-1:0] sel_hi;
  logic [N_CH-1:0] dead_ch;
  for (genvar c = 0; c < N_CH; c++) begin : g_m
    assign sel_hi[c]  = sel_o[c*SEL_W+1];
    assign dead_ch[c] = ~|SLOT_EN[c*N_SLOT +: N_SLOT];
  end

  AST_LEG_NO_SLOT2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == ADDR_W'(LEG_ADDR) |=> sel_hi == '0); // R4

  AST_LEG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == ADDR_W'(LEG_ADDR) |=>
      (rd_addr_i != ADDR_W'(LEG_ADDR) || rd_data_o[N_CH-1:0] == $past(wr_data_i[N_CH-1:0]))); // R6

  AST_DEAD_CH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_req_o & dead_ch) == '0); // R8

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int F = (c % CH_PER_W) * FLD_W;

    AST_NONE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_o[c*SEL_W +: SEL_W] == SEL_NONE |-> !chan_req_o[c]); // R3

    AST_FLD_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_addr_i == ADDR_W'(c / CH_PER_W) |=>
        sel_o[c*SEL_W +: SEL_W] ==
          (($past(wr_data_i[F +: FLD_W]) > 4'd2) ? 2'd3 : $past(wr_data_i[F +: SEL_W]))); // R5
  end
endmodule

bind chan_src_mapper chan_src_mapper_chk #(
  .N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_EN(SLOT_EN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .sel_o      (sel_o),
  .chan_req_o (chan_req_o)
);

// File: tb/chan_src_mapper_tb_top.sv
`timescale 1ns/1ps
module chan_src_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [95:0] req_i = '0;
  logic [63:0] sel_o;
  logic [31:0] chan_req_o;

  int n_run = 0;
  int n_fail = 0;

  logic [3:0]  m_fld [32];
  logic [31:0] m_leg;
  logic [31:0] m_wins;

  always #5 clk_i = ~clk_i;

  chan_src_mapper dut_i (.*);

  function automatic logic [1:0] f_sel(int c);
    if (!m_wins[c]) return {1'b0, m_leg[c]};
    if (m_fld[c] > 4'd2) return 2'd3;
    return m_fld[c][1:0];
  endfunction

  function automatic logic [63:0] f_sel_vec();
    logic [63:0] v;
    for (int c = 0; c < 32; c++) v[c*2 +: 2] = f_sel(c);
    return v;
  endfunction

  function automatic logic [31:0] f_req_vec(logic [95:0] r);
    logic [31:0] v;
    for (int c = 0; c < 32; c++) begin
      logic [1:0] s;
      s = f_sel(c);
      v[c] = (s == 2'd3 || c >= 30) ? 1'b0 : r[c*3 + int'(s)];
    end
    return v;
  endfunction

  function automatic logic [31:0] f_rd(logic [2:0] a);
    logic [31:0] v;
    v = '0;
    if (a < 3'd4) for (int k = 0; k < 8; k++) v[k*4 +: 4] = m_fld[int'(a)*8 + k];
    else if (a == 3'd4) v = m_leg;
    return v;
  endfunction

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " sel"}, 96'(sel_o), 96'(f_sel_vec()));
    chk({tag, " req"}, 96'(chan_req_o), 96'(f_req_vec(req_i)));
    chk({tag, " rd"}, 96'(rd_data_o), 96'(f_rd(rd_addr_i)));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    if (a < 3'd4) begin
      for (int k = 0; k < 8; k++) begin
        m_fld[int'(a)*8 + k] = d[k*4 +: 4];
        m_wins[int'(a)*8 + k] = 1'b1;
      end
    end else if (a == 3'd4) begin
      m_leg = d; m_wins = '0;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  task automatic set_in(logic [95:0] r, logic [2:0] ra);
    req_i = r; rd_addr_i = ra;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5EED_C0DE);
    for (int c = 0; c < 32; c++) m_fld[c] = '0;
    m_leg = '0; m_wins = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;

    // R1 reset state, every readable address
    for (int a = 0; a < 8; a++) begin
      set_in('1, 3'(a));
      chk("R1 reset", {rd_data_o, sel_o}, {32'h0, 64'h0});
    end
    chk("R7 reset slot0 routing", 96'(chan_req_o), 96'(32'h3FFF_FFFF));

    // R2/R3 field encodings in word 0: ch0..7 = 0,1,2,3,15,2,1,0
    wr(3'd0, 32'h012F_3210);
    set_in(96'h0, 3'd0);
    chk("R2 field select", 96'(sel_o[15:0]), 96'({2'd0,2'd1,2'd2,2'd3,2'd3,2'd2,2'd1,2'd0}));
    set_in('1, 3'd0);
    chk("R3 reserved blocks req", 96'(chan_req_o[4:3]), 96'(2'b00));
    chk_all("R2");

    // R7 single-slot patterns
    for (int s = 0; s < 3; s++) begin
      logic [95:0] r;
      r = '0;
      for (int c = 0; c < 32; c++) r[c*3+s] = 1'b1;
      set_in(r, 3'd0);
      chk_all("R7 slot pattern");
    end

    // R4/R5 legacy write overrides field words
    wr(3'd4, 32'hA5A5_00FF);
    set_in('1, 3'd4);
    chk("R4 legacy sel", 96'(sel_o[15:0]), 96'(16'h5555));
    chk("R6 legacy readback", 96'(rd_data_o), 96'(32'hA5A5_00FF));
    chk_all("R5 legacy after field");

    // R5/R6 field write after legacy: only word 1 reclaimed
    wr(3'd1, 32'h2222_2222);
    set_in('1, 3'd4);
    chk("R5 field after legacy", 96'(sel_o[31:16]), 96'(16'hAAAA));
    chk("R6 legacy read unchanged", 96'(rd_data_o), 96'(32'hA5A5_00FF));
    chk_all("R5 mix");

    // R8 dead channels with all requests on every slot choice
    wr(3'd3, 32'h2100_0000);
    set_in('1, 3'd3);
    chk("R8 ch30/31 quiet", 96'(chan_req_o[31:30]), 96'(2'b00));
    wr(3'd4, 32'hC000_0000);
    set_in('1, 3'd3);
    chk("R8 ch30/31 quiet legacy", 96'(chan_req_o[31:30]), 96'(2'b00));

    // R9 unmapped writes ignored
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      set_in('1, 3'(a));
      chk("R9 unmapped", 96'(rd_data_o), 96'(0));
      chk_all("R9 state kept");
    end

    // random mix of writes, requests and reads
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom_range(0, 7));
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & 32'h3333_3333;
      wr(a, d);
      set_in({$urandom(), $urandom(), $urandom()}, 3'($urandom_range(0, 7)));
      chk_all("R2 R4 R5 R6 R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule